// File: doc/BRIEF.md
# Banked Line-Refill Memory Responder

This block is the memory side of a cache refill path. It holds its storage as several word-wide banks. Consecutive word addresses are spread across the banks, so word k of any aligned line always sits in bank k. A requester presents a word address on a valid/ready port. A read returns the whole aligned line that contains that address, one word per cycle on a single-word bus. Each returned word is tagged with its position in the line. A write changes exactly one word in the bank that owns it and raises a completion strobe.

The timing model is fixed. The cycle in which the request is accepted is the address cycle. Every bank access then costs a fixed number of cycles, and every returned word costs one more cycle. A parameter selects one of two organizations:
- **Interleaved:** all banks are read together in one latency window, and the words stream back back to back. A four-word line finishes 1 + 15 + 4 = 20 cycles after the address cycle begins.
- **Sequential:** a single word-wide memory pays the full latency again for every word, so the same line takes 1 + 4×15 + 4×1 = 65 cycles.

Two instances, one of each mode, can be driven side by side to compare miss penalties cycle for cycle.

Controller states:
- **ST_IDLE:** ready for a request.
- **ST_ACCESS:** the latency window is running.
- **ST_XFER:** a word is on the bus.

Transitions:
- **accept:** ST_IDLE to ST_ACCESS on a handshake.
- **write_commit:** ST_ACCESS to ST_IDLE when the window of a write expires.
- **line_ready:** ST_ACCESS to ST_XFER when the window of a read expires.
- **next_beat:** ST_XFER stays in ST_XFER in interleaved mode for each word before the last.
- **reaccess:** ST_XFER to ST_ACCESS in sequential mode for each word before the last.
- **line_done:** ST_XFER to ST_IDLE after the last word.

Top module: `ilv_mem_responder`

## Requirements
Cycles are counted from the cycle in which the request handshake occurs, which is cycle 1. The defaults are 4 banks, a latency of 15 and 32-bit words.

- R1: After reset, `req_ready` is 1 and both `resp_valid` and `wr_done` are 0. Every word of the storage reads as zero.
- R2: `req_ready` is 1 only while idle. It drops in cycle 2 and returns:
  - in cycle 21 after an interleaved read;
  - in cycle 66 after a sequential read;
  - in cycle 17 after a write.
- R3: In interleaved mode a read returns its words in cycles 17, 18, 19 and 20. `resp_idx` is 0, 1, 2, 3 in that order, and `resp_data` for index k is the word at line base + k.
- R4: In sequential mode a read returns word k in cycle 17 + 16·k, that is in cycles 17, 33, 49 and 65. `resp_valid` is 0 in every other cycle.
- R5: The line base is the request address with its two low bits cleared. A read at any address inside a line returns that whole line starting at index 0, including the topmost line of the address space.
- R6: A write to word address a changes only that word: bank a mod 4, row a div 4. The other three words of its line keep their values.
- R7: `wr_done` is 1 in cycle 16 of a write and in no other cycle of the write. The new value is visible to any later read.
- R8: `resp_valid` and `wr_done` are never 1 in the same cycle, and no word is returned during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 for a single-word write, 0 for a line read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Data for a write |
| resp_valid | output | 1 | A returned word is on resp_data |
| resp_idx | output | log2(NUM_BANKS) | Position of the returned word in its line |
| resp_data | output | DATA_W | Returned word |
| wr_done | output | 1 | Single-cycle strobe: the write commits at the end of this cycle |

## Verification
The assertions assume that the requester never holds `req_valid` high across a busy period and then expects it to be taken early. Only a handshake in ST_IDLE counts as a request.

They also assume `req_addr` and `req_write` are stable in the handshake cycle, because both are sampled only at that edge.

The stimulus drives the inputs on the falling edge and raises `req_valid` for exactly one cycle while both instances are idle. It then waits until the slower sequential instance has finished, so no request ever overlaps a busy responder.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_XFER   = 2'd2
    } mem_state_e;

endpackage

// File: rtl/ilv_mem_bank.sv
module ilv_mem_bank #(
    parameter int DATA_W = 32,
    parameter int ROW_W  = 6,
    localparam int ROWS  = 1 << ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  rd_row,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                cells[r] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_row] <= wr_data;
        end
    end

    assign rd_data = cells[rd_row];

endmodule

// File: rtl/ilv_mem_latency_ctr.sv
module ilv_mem_latency_ctr #(
    parameter int LAT   = 15,
    localparam int CNT_W = (LAT < 2) ? 1 : $clog2(LAT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(LAT - 1);
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2: a fresh window never reports expiry in its first cycle when LAT > 1
    assert_window_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && LAT > 1) |=> !expired);

endmodule

// File: rtl/ilv_mem_line_buf.sv
module ilv_mem_line_buf #(
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 2,
    parameter int WIDE      = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             capture,
    input  logic [IDX_W-1:0]                 cap_idx,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] bank_words,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] line_words
);

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        logic take;
        // wide organization loads every word at once; narrow loads only the word in flight
        assign take = capture && ((WIDE != 0) || (cap_idx == IDX_W'(k)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_words[k] <= '0;
            end else if (take) begin
                line_words[k] <= bank_words[k];
            end
        end
    end

endmodule

// File: rtl/ilv_mem_responder.sv
module ilv_mem_responder
    import ilv_mem_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int NUM_BANKS   = 4,
    parameter int ACCESS_LAT  = 15,
    parameter int INTERLEAVED = 1,
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int ROW_W      = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [BANK_W-1:0] resp_idx,
    output logic [DATA_W-1:0] resp_data,
    output logic              wr_done
);

    mem_state_e state_q, state_d;

    logic              op_wr_q;
    logic [ROW_W-1:0]  row_q;
    logic [BANK_W-1:0] widx_q;
    logic [DATA_W-1:0] wdata_q;

    logic accept, acc_expired, last_word, ctr_load, ctr_run, capture;
    logic [NUM_BANKS-1:0]             bank_we;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd;
    logic [NUM_BANKS-1:0][DATA_W-1:0] line_q;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign last_word = (widx_q == BANK_W'(NUM_BANKS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_ACCESS;
            ST_ACCESS: if (acc_expired) state_d = op_wr_q ? ST_IDLE : ST_XFER;
            ST_XFER: begin
                if (last_word)             state_d = ST_IDLE;
                else if (INTERLEAVED == 0) state_d = ST_ACCESS;
                else                       state_d = ST_XFER;
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        wr_done    = 1'b0;
        capture    = 1'b0;
        ctr_load   = 1'b0;
        ctr_run    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                ctr_load  = accept;
            end
            ST_ACCESS: begin
                ctr_run = 1'b1;
                wr_done = acc_expired && op_wr_q;
                capture = acc_expired && !op_wr_q;
            end
            ST_XFER: begin
                resp_valid = 1'b1;
                ctr_load   = (INTERLEAVED == 0) && !last_word;
            end
            default: ;
        endcase
    end

    assign resp_idx  = widx_q;
    assign resp_data = line_q[widx_q];

    // request capture and word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
            row_q   <= '0;
            widx_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_wr_q <= req_write;
            row_q   <= req_addr[ADDR_W-1:BANK_W];
            widx_q  <= req_write ? req_addr[BANK_W-1:0] : '0;
            wdata_q <= req_wdata;
        end else if (state_q == ST_XFER && !last_word) begin
            widx_q  <= widx_q + 1'b1;
        end
    end

    ilv_mem_latency_ctr #(.LAT(ACCESS_LAT)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctr_load),
        .run     (ctr_run),
        .expired (acc_expired)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_we[b] = wr_done && (widx_q == BANK_W'(b));
        ilv_mem_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_we[b]),
            .wr_row  (row_q),
            .wr_data (wdata_q),
            .rd_row  (row_q),
            .rd_data (bank_rd[b])
        );
    end

    ilv_mem_line_buf #(
        .DATA_W(DATA_W), .NUM_WORDS(NUM_BANKS), .IDX_W(BANK_W), .WIDE(INTERLEAVED)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (capture),
        .cap_idx    (widx_q),
        .bank_words (bank_rd),
        .line_words (line_q)
    );

    // ---------------- assertions ----------------
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_ready_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> req_ready);

    assert_beats_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (INTERLEAVED != 0 && resp_valid && resp_idx != BANK_W'(NUM_BANKS - 1))
        |=> (resp_valid && resp_idx == $past(resp_idx) + 1'b1));

    assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_idx == '0) |-> !$past(resp_valid));

    assert_seq_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (INTERLEAVED == 0 && resp_valid) |=> !resp_valid);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(resp_valid && wr_done));

    assert_one_bank_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

endmodule

// File: tb/ilv_mem_responder_tb.sv
`timescale 1ns/1ps
module ilv_mem_responder_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;

    logic        i_ready, i_valid, i_wdone;
    logic [1:0]  i_idx;
    logic [31:0] i_data;
    logic        s_ready, s_valid, s_wdone;
    logic [1:0]  s_idx;
    logic [31:0] s_data;

    logic [31:0] model [256];
    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    ilv_mem_responder #(.INTERLEAVED(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(i_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(i_valid), .resp_idx(i_idx), .resp_data(i_data), .wr_done(i_wdone));

    ilv_mem_responder #(.INTERLEAVED(0)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(s_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(s_valid), .resp_idx(s_idx), .resp_data(s_data), .wr_done(s_wdone));

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(i_ready == 1'b1, "R1", "ready after reset", 32'(i_ready), 1);
        chk(s_ready == 1'b1, "R1", "seq ready after reset", 32'(s_ready), 1);
        chk(i_valid == 1'b0 && s_valid == 1'b0, "R1", "no response after reset",
            32'(i_valid | s_valid), 0);
        chk(i_wdone == 1'b0 && s_wdone == 1'b0, "R1", "no write done after reset",
            32'(i_wdone | s_wdone), 0);
    endtask

    // one write; both organizations take the same time
    task automatic do_write(input logic [7:0] addr, input logic [31:0] val);
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr; req_wdata = val;
        chk(i_ready && s_ready, "R2", "ready before write", 32'(i_ready & s_ready), 1);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        for (int c = 2; c <= 17; c++) begin
            chk(i_wdone == (c == 16), "R7", $sformatf("wr_done cycle %0d", c), 32'(i_wdone), 32'(c == 16));
            chk(s_wdone == (c == 16), "R7", $sformatf("seq wr_done cycle %0d", c), 32'(s_wdone), 32'(c == 16));
            chk(!i_valid && !s_valid, "R8", $sformatf("no beat in write cycle %0d", c),
                32'(i_valid | s_valid), 0);
            chk(i_ready == (c >= 17), "R2", $sformatf("ready in write cycle %0d", c), 32'(i_ready), 32'(c >= 17));
            @(negedge clk);
        end
        model[addr] = val;
    endtask

    // one read, both organizations checked against their own schedule
    task automatic do_read(input logic [7:0] addr, input string req);
        logic [7:0] base;
        base = addr & 8'hFC;
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr;
        chk(i_ready && s_ready, "R2", "ready before read", 32'(i_ready & s_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 2; c <= 66; c++) begin
            logic iv, sv;
            int ik, sk;
            iv = (c >= 17) && (c <= 20);
            ik = c - 17;
            sv = (c >= 17) && (c <= 65) && (((c - 17) % 16) == 0);
            sk = (c - 17) / 16;
            chk(i_valid == iv, "R3", $sformatf("%s ilv valid cycle %0d", req, c), 32'(i_valid), 32'(iv));
            if (iv && i_valid) begin
                chk(i_idx == 2'(ik), "R3", $sformatf("%s ilv idx", req), 32'(i_idx), 32'(ik));
                chk(i_data == model[base + 8'(ik)], req, $sformatf("ilv data word %0d", ik),
                    i_data, model[base + 8'(ik)]);
            end
            chk(s_valid == sv, "R4", $sformatf("%s seq valid cycle %0d", req, c), 32'(s_valid), 32'(sv));
            if (sv && s_valid) begin
                chk(s_idx == 2'(sk), "R4", $sformatf("%s seq idx", req), 32'(s_idx), 32'(sk));
                chk(s_data == model[base + 8'(sk)], req, $sformatf("seq data word %0d", sk),
                    s_data, model[base + 8'(sk)]);
            end
            chk(i_ready == (c >= 21), "R2", $sformatf("ilv ready cycle %0d", c), 32'(i_ready), 32'(c >= 21));
            chk(s_ready == (c >= 66), "R2", $sformatf("seq ready cycle %0d", c), 32'(s_ready), 32'(c >= 66));
            chk(!i_wdone && !s_wdone, "R8", "no write done during read", 32'(i_wdone | s_wdone), 0);
            @(negedge clk);
        end
    endtask

    task automatic test_zero_line();
        do_read(8'h20, "R1");
    endtask

    task automatic test_line_fill();
        do_write(8'h40, 32'hA000_0000);
        do_write(8'h41, 32'hA111_1111);
        do_write(8'h42, 32'hA222_2222);
        do_write(8'h43, 32'hA333_3333);
        do_read(8'h40, "R3");
    endtask

    task automatic test_unaligned();
        do_read(8'h43, "R5");
        do_read(8'h42, "R5");
    endtask

    task automatic test_single_word();
        do_write(8'h41, 32'h5EED_0041);
        do_read(8'h40, "R6");
    endtask

    task automatic test_top_line();
        do_write(8'hFC, 32'h0000_00FC);
        do_write(8'hFF, 32'hFFFF_00FF);
        do_read(8'hFE, "R5");
    endtask

    logic finished = 1'b0;

    initial begin
        for (int a = 0; a < 256; a++) model[a] = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk(i_ready == 1'b1, "R1", "ready during reset", 32'(i_ready), 1);
        rst_n = 1'b1;
        test_reset();
        test_zero_line();
        test_line_fill();
        test_unaligned();
        test_single_word();
        test_top_line();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule